// File: doc/BRIEF.md
# Image Output Port Serializer

This block is the transmit side of a video image port. It takes 32-bit double-words from two independent upstream FIFOs. One FIFO holds scaled video. The other holds sliced VBI (vertical blanking interval) data. The block picks one source per double-word and serializes the chosen word onto a 16-bit output bus. In byte mode only the low lane is used and the word goes out as four bytes. In word mode both lanes are used and the word goes out as two 16-bit words. Every cycle that carries data is marked by a qualifier. A mode input turns the qualifier pin into a gated clock, which pulses only for valid cycles.

VBI data has priority. A VBI line starts only when its FIFO reports that a whole line is present. Once it starts, the line is sent as one unbroken block, and video is held off until the double-word flagged as the last of the line has been taken. A flag output marks every output cycle that carries VBI bytes.

For pin-constrained receivers, byte mode can embed start-of-active-video and end-of-active-video timing codes around each video line. These codes are patterned on the 656 convention, so the receiver needs only the eight data pins and one clock pin. The mode inputs are expected to change only while the port is idle.

Top module: `img_out_serializer`

## Requirements
- R1: In byte mode (`cfg_wide`=0), a double-word goes out on `out_data[7:0]` over four consecutive valid cycles in the order bits 7:0, 15:8, 23:16, 31:24 (Cb, Y0, Cr, Y1), and `out_data[15:8]` is 0. The first byte appears on the second rising edge after the cycle in which the word is popped. Words that are already available follow one another with no idle cycle between them.
- R2: In word mode (`cfg_wide`=1), a double-word goes out over two valid cycles. `out_data[7:0]` is the chroma lane and carries byte 0, then byte 2. `out_data[15:8]` is the luma lane and carries byte 1, then byte 3.
- R3: With `cfg_gate_clk`=0, `out_qual` is 1 exactly on cycles that carry output data. On every other cycle `out_qual` is 0 and `out_data` is 0.
- R4: With `cfg_gate_clk`=1, `out_qual` is 0 during every low phase of `clk`. It is high during the high phase that starts at the rising edge ending a valid cycle, and low during every other high phase.
- R5: When a double-word boundary is reached, `vbi_line_ready` and `vbi_valid` are both high and no VBI line is in progress, the VBI source is popped and the video source is not.
- R6: Once the first double-word of a VBI line is popped, `vid_pop` stays low until the double-word with `vbi_last`=1 has been popped. No VBI word is popped to start a line while `vbi_line_ready` is 0.
- R7: `out_vbi_flag` is 1 exactly on the output cycles that carry bytes of a VBI double-word.
- R8: In byte mode with `cfg_embed_codes`=1, a video word with `vid_sol`=1 is preceded by a start code, and a video word with `vid_eol`=1 is followed by an end code. Each code is the byte sequence FF, 00, 00, XY. In XY, bit 7 is 1, bit 6 is the field F, bit 5 is the blanking flag V, and bit 4 is H (0 for the start code, 1 for the end code). Bits 3 to 0 of XY are V^H, F^H, F^V and F^V^H. F and V come from the marked word.
- R9: In word mode, `cfg_embed_codes` has no effect and no codes are inserted.
- R10: Sources are popped only when the serializer is idle or presenting the last beat of its current item, so that consecutive pops are at least four cycles apart in byte mode and at least two in word mode.
- R11: While `rst` is high, `out_data`, `out_qual`, `out_vbi_flag`, `vid_pop` and `vbi_pop` are 0 at the sampled points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1: 16-bit word mode, 0: byte mode |
| cfg_gate_clk | input | 1 | 1: qualifier pin carries a gated clock |
| cfg_embed_codes | input | 1 | 1: insert timing codes in byte mode |
| vid_valid | input | 1 | Video FIFO has a double-word |
| vid_data | input | 32 | Video double-word |
| vid_sol | input | 1 | Word is the first of a video line |
| vid_eol | input | 1 | Word is the last of a video line |
| vid_field | input | 1 | Field bit for the line |
| vid_vblank | input | 1 | Blanking bit for the line |
| vid_pop | output | 1 | Video FIFO read strobe |
| vbi_valid | input | 1 | VBI FIFO has a double-word |
| vbi_data | input | 32 | VBI double-word |
| vbi_last | input | 1 | Word ends the VBI line |
| vbi_line_ready | input | 1 | A complete VBI line is stored |
| vbi_pop | output | 1 | VBI FIFO read strobe |
| out_data | output | 16 | Output bus (chroma low lane, luma high lane) |
| out_qual | output | 1 | Data-valid qualifier or gated clock |
| out_vbi_flag | output | 1 | Marks VBI output cycles |

## Verification
Back-to-back video in byte and word mode shows that lane order and beat order are right and that no bubbles appear. Single words separated by long gaps show that the qualifier and the idle zeros follow the data exactly. A VBI line queued together with video shows priority and unbroken delivery. A partial VBI line, completed while video is streaming, shows that a line waits for completeness and then cuts in only at a double-word boundary. Code insertion is tried on multi-word lines, on single-word lines and with every F/V combination, and again in word mode where it must have no effect. A gated-clock run with gaps separates correct pulses from a level or from a pulse in the wrong phase.

// File: rtl/img_port_pkg.sv
`timescale 1ns/1ps
package img_port_pkg;

  typedef enum logic [1:0] {
    K_VID = 2'd0,
    K_VBI = 2'd1,
    K_SAV = 2'd2,
    K_EAV = 2'd3
  } item_kind_t;

  // status byte of a timing code: marker, field, blanking, edge, parity
  function automatic logic [7:0] timing_xy(input logic f, input logic v, input logic h);
    timing_xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/img_src_arb.sv
`timescale 1ns/1ps
module img_src_arb (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic vid_valid,
  input  logic vbi_valid,
  input  logic vbi_line_ready,
  input  logic vbi_last,
  output logic grant_vid,
  output logic grant_vbi
);

  logic in_line;

  always_comb begin
    grant_vbi = take && vbi_valid && (in_line || vbi_line_ready);
    grant_vid = take && vid_valid && !in_line && !(vbi_valid && vbi_line_ready);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_line <= 1'b0;
    end else if (grant_vbi) begin
      in_line <= !vbi_last;
    end
  end

endmodule

// File: rtl/img_item_seq.sv
`timescale 1ns/1ps
module img_item_seq
  import img_port_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                boundary,
  input  logic                embed_en,
  input  logic                grant_vid,
  input  logic                grant_vbi,
  input  logic [4*LANE_W-1:0] vid_data,
  input  logic                vid_sol,
  input  logic                vid_eol,
  input  logic                vid_field,
  input  logic                vid_vblank,
  input  logic [4*LANE_W-1:0] vbi_data,
  output logic                take,
  output logic                nxt_valid,
  output item_kind_t          nxt_kind,
  output logic [4*LANE_W-1:0] nxt_word
);

  localparam int DW_W = 4 * LANE_W;

  logic            pend_data;
  logic            pend_eav;
  logic            line_f;
  logic            line_v;
  logic [DW_W-1:0] hold_q;

  function automatic logic [DW_W-1:0] code_word(input logic f, input logic v, input logic h);
    code_word = {LANE_W'(timing_xy(f, v, h)), {LANE_W{1'b0}}, {LANE_W{1'b0}}, {LANE_W{1'b1}}};
  endfunction

  always_comb begin
    take      = boundary && !pend_data && !pend_eav;
    nxt_valid = 1'b0;
    nxt_kind  = K_VID;
    nxt_word  = '0;
    if (boundary) begin
      if (pend_data) begin
        nxt_valid = 1'b1;
        nxt_word  = hold_q;
      end else if (pend_eav) begin
        nxt_valid = 1'b1;
        nxt_kind  = K_EAV;
        nxt_word  = code_word(line_f, line_v, 1'b1);
      end else if (grant_vbi) begin
        nxt_valid = 1'b1;
        nxt_kind  = K_VBI;
        nxt_word  = vbi_data;
      end else if (grant_vid) begin
        nxt_valid = 1'b1;
        if (embed_en && vid_sol) begin
          nxt_kind = K_SAV;
          nxt_word = code_word(vid_field, vid_vblank, 1'b0);
        end else begin
          nxt_word = vid_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_data <= 1'b0;
      pend_eav  <= 1'b0;
      line_f    <= 1'b0;
      line_v    <= 1'b0;
      hold_q    <= '0;
    end else if (boundary) begin
      if (pend_data) begin
        pend_data <= 1'b0;
      end else if (pend_eav) begin
        pend_eav <= 1'b0;
      end else if (grant_vid && embed_en) begin
        line_f    <= vid_field;
        line_v    <= vid_vblank;
        pend_data <= vid_sol;
        pend_eav  <= vid_eol;
        hold_q    <= vid_data;
      end
    end
  end

endmodule

// File: rtl/img_beat_ser.sv
`timescale 1ns/1ps
module img_beat_ser
  import img_port_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wide,
  input  logic                nxt_valid,
  input  item_kind_t          nxt_kind,
  input  logic [4*LANE_W-1:0] nxt_word,
  output logic                boundary,
  output logic [2*LANE_W-1:0] out_data,
  output logic                out_dv,
  output logic                out_vbi
);

  localparam int DW_W       = 4 * LANE_W;
  localparam int OUT_W      = 2 * LANE_W;
  localparam int BYTE_BEATS = DW_W / LANE_W;
  localparam int WIDE_BEATS = DW_W / OUT_W;
  localparam int BEAT_W     = $clog2(BYTE_BEATS);

  logic              busy;
  logic [BEAT_W-1:0] beat;
  logic [DW_W-1:0]   cur;
  item_kind_t        cur_kind;
  logic              cur_wide;
  logic              last_beat;
  logic [OUT_W-1:0]  sel;

  always_comb begin
    last_beat = busy && (beat == (cur_wide ? BEAT_W'(WIDE_BEATS - 1) : BEAT_W'(BYTE_BEATS - 1)));
    boundary  = !busy || last_beat;
    if (cur_wide) begin
      sel = beat[0] ? cur[DW_W-1 -: OUT_W] : cur[OUT_W-1:0];
    end else begin
      sel = {{LANE_W{1'b0}}, cur[beat*LANE_W +: LANE_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      beat     <= '0;
      cur      <= '0;
      cur_kind <= K_VID;
      cur_wide <= 1'b0;
      out_data <= '0;
      out_dv   <= 1'b0;
      out_vbi  <= 1'b0;
    end else begin
      out_dv   <= busy;
      out_vbi  <= busy && (cur_kind == K_VBI);
      out_data <= busy ? sel : '0;
      if (boundary) begin
        busy <= nxt_valid;
        beat <= '0;
        if (nxt_valid) begin
          cur      <= nxt_word;
          cur_kind <= nxt_kind;
          cur_wide <= wide;
        end
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

endmodule

// File: rtl/img_qual_out.sv
`timescale 1ns/1ps
module img_qual_out (
  input  logic clk,
  input  logic rst,
  input  logic gate_en,
  input  logic dv,
  output logic qual
);

  logic en_lo;

  // enable changes only while the clock is low, so the pulse is whole
  always_ff @(negedge clk) begin
    if (rst) begin
      en_lo <= 1'b0;
    end else begin
      en_lo <= dv;
    end
  end

  assign qual = gate_en ? (clk & en_lo) : dv;

endmodule

// File: rtl/img_out_serializer.sv
`timescale 1ns/1ps
module img_out_serializer
  import img_port_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wide,
  input  logic                cfg_gate_clk,
  input  logic                cfg_embed_codes,
  input  logic                vid_valid,
  input  logic [4*LANE_W-1:0] vid_data,
  input  logic                vid_sol,
  input  logic                vid_eol,
  input  logic                vid_field,
  input  logic                vid_vblank,
  output logic                vid_pop,
  input  logic                vbi_valid,
  input  logic [4*LANE_W-1:0] vbi_data,
  input  logic                vbi_last,
  input  logic                vbi_line_ready,
  output logic                vbi_pop,
  output logic [2*LANE_W-1:0] out_data,
  output logic                out_qual,
  output logic                out_vbi_flag
);

  localparam int DW_W = 4 * LANE_W;

  logic            boundary;
  logic            take;
  logic            grant_vid;
  logic            grant_vbi;
  logic            nxt_valid;
  item_kind_t      nxt_kind;
  logic [DW_W-1:0] nxt_word;
  logic            dv;
  logic            embed_en;

  assign embed_en = cfg_embed_codes && !cfg_wide;
  assign vid_pop  = grant_vid;
  assign vbi_pop  = grant_vbi;

  img_src_arb u_arb (
    .clk            (clk),
    .rst            (rst),
    .take           (take),
    .vid_valid      (vid_valid),
    .vbi_valid      (vbi_valid),
    .vbi_line_ready (vbi_line_ready),
    .vbi_last       (vbi_last),
    .grant_vid      (grant_vid),
    .grant_vbi      (grant_vbi)
  );

  img_item_seq #(.LANE_W(LANE_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .boundary   (boundary),
    .embed_en   (embed_en),
    .grant_vid  (grant_vid),
    .grant_vbi  (grant_vbi),
    .vid_data   (vid_data),
    .vid_sol    (vid_sol),
    .vid_eol    (vid_eol),
    .vid_field  (vid_field),
    .vid_vblank (vid_vblank),
    .vbi_data   (vbi_data),
    .take       (take),
    .nxt_valid  (nxt_valid),
    .nxt_kind   (nxt_kind),
    .nxt_word   (nxt_word)
  );

  img_beat_ser #(.LANE_W(LANE_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .wide      (cfg_wide),
    .nxt_valid (nxt_valid),
    .nxt_kind  (nxt_kind),
    .nxt_word  (nxt_word),
    .boundary  (boundary),
    .out_data  (out_data),
    .out_dv    (dv),
    .out_vbi   (out_vbi_flag)
  );

  img_qual_out u_qual (
    .clk     (clk),
    .rst     (rst),
    .gate_en (cfg_gate_clk),
    .dv      (dv),
    .qual    (out_qual)
  );

endmodule

// File: rtl/img_out_serializer_chk.sv
`timescale 1ns/1ps
module img_out_serializer_chk #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_wide,
  input logic                cfg_gate_clk,
  input logic                vid_pop,
  input logic                vbi_pop,
  input logic                vbi_valid,
  input logic                vbi_last,
  input logic                vbi_line_ready,
  input logic [2*LANE_W-1:0] out_data,
  input logic                out_qual,
  input logic                out_vbi_flag
);

  logic [2:0] since_pop;
  logic       chk_in_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_pop   <= 3'd7;
      chk_in_line <= 1'b0;
    end else begin
      if (vid_pop || vbi_pop) begin
        since_pop <= 3'd1;
      end else if (since_pop != 3'd7) begin
        since_pop <= since_pop + 3'd1;
      end
      if (vbi_pop) begin
        chk_in_line <= !vbi_last;
      end
    end
  end

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_gate_clk && !out_qual) |-> (out_data == '0));

  // R5
  vbi_first_chk: assert property (@(posedge clk) disable iff (rst)
    vid_pop |-> !(vbi_valid && vbi_line_ready));

  // R6
  single_pop_chk: assert property (@(posedge clk) disable iff (rst)
    !(vid_pop && vbi_pop));

  // R6
  line_block_chk: assert property (@(posedge clk) disable iff (rst)
    chk_in_line |-> !vid_pop);

  // R7
  vbi_flag_qual_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_gate_clk && out_vbi_flag) |-> out_qual);

  // R10
  pop_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (vid_pop || vbi_pop) |-> (since_pop >= (cfg_wide ? 3'd2 : 3'd4)));

endmodule

bind img_out_serializer img_out_serializer_chk #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/img_out_serializer_bench.sv
`timescale 1ns/1ps
module img_out_serializer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wide = 1'b0;
  logic        cfg_gate_clk = 1'b0;
  logic        cfg_embed_codes = 1'b0;
  logic        vid_valid = 1'b0;
  logic [31:0] vid_data = '0;
  logic        vid_sol = 1'b0;
  logic        vid_eol = 1'b0;
  logic        vid_field = 1'b0;
  logic        vid_vblank = 1'b0;
  logic        vid_pop;
  logic        vbi_valid = 1'b0;
  logic [31:0] vbi_data = '0;
  logic        vbi_last = 1'b0;
  logic        vbi_line_ready = 1'b0;
  logic        vbi_pop;
  logic [15:0] out_data;
  logic        out_qual;
  logic        out_vbi_flag;

  always #2.5 clk = ~clk;

  img_out_serializer u_img_out_serializer (.*);

  // reference state
  logic [35:0] vq[$];    // {sol, eol, field, vblank, data}
  logic [32:0] bq[$];    // {last, data}
  logic [16:0] pend[$];  // {vbi, data} beats still to appear
  logic [31:0] hold[$];  // items owed before the next arbitration
  bit          in_line = 0;
  logic        exp_dv = 0, exp_vbi = 0, prev_dv = 0;
  logic [15:0] exp_data = '0;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;
  string       tag = "R11";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_code(input bit f, input bit v, input bit h);
    logic [7:0] xy;
    xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    return {xy, 8'h00, 8'h00, 8'hFF};
  endfunction

  task automatic expand(input logic [31:0] w, input bit is_vbi);
    if (cfg_wide) begin
      pend.push_back({is_vbi, w[15:0]});
      pend.push_back({is_vbi, w[31:16]});
    end else begin
      for (int i = 0; i < 4; i++) pend.push_back({is_vbi, 8'h00, w[8*i +: 8]});
    end
  endtask

  task automatic drive();
    vid_valid = (vq.size() > 0);
    if (vid_valid) {vid_sol, vid_eol, vid_field, vid_vblank, vid_data} = vq[0];
    else {vid_sol, vid_eol, vid_field, vid_vblank, vid_data} = '0;
    vbi_valid = (bq.size() > 0);
    if (vbi_valid) {vbi_last, vbi_data} = bq[0];
    else {vbi_last, vbi_data} = '0;
    vbi_line_ready = 1'b0;
    foreach (bq[i]) if (bq[i][32]) vbi_line_ready = 1'b1;
  endtask

  task automatic model();
    bit          bnd, ev_pop, eb_pop, emb, have;
    logic [16:0] e;
    logic [35:0] v;
    logic [32:0] b;
    bnd    = (pend.size() <= 1);
    have   = (pend.size() > 0);
    e      = have ? pend.pop_front() : '0;
    ev_pop = 0;
    eb_pop = 0;
    if (bnd) begin
      if (hold.size() > 0) begin
        expand(hold.pop_front(), 0);
      end else if (bq.size() > 0 && (in_line || vbi_line_ready)) begin
        eb_pop = 1;
        b = bq.pop_front();
        in_line = !b[32];
        expand(b[31:0], 1);
      end else if (!in_line && vq.size() > 0) begin
        ev_pop = 1;
        v = vq.pop_front();
        emb = cfg_embed_codes && !cfg_wide;
        if (emb && v[35]) begin
          expand(ref_code(v[33], v[32], 0), 0);
          hold.push_back(v[31:0]);
        end else begin
          expand(v[31:0], 0);
        end
        if (emb && v[34]) hold.push_back(ref_code(v[33], v[32], 1));
      end
    end
    chk("R10 vid_pop", vid_pop, ev_pop);
    chk("R5 vbi_pop", vbi_pop, eb_pop);
    prev_dv  = exp_dv;
    exp_dv   = have;
    exp_vbi  = have & e[16];
    exp_data = e[15:0];
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    chk(tag, out_data, exp_data);
    chk("R7 vbi flag", out_vbi_flag, exp_vbi);
    if (cfg_gate_clk) chk("R4 gated high phase", out_qual, prev_dv);
    else chk("R3 qualifier", out_qual, exp_dv);
    drive();
    #1;
    model();
    if (cfg_gate_clk) begin
      @(negedge clk);
      #1;
      chk("R4 gated low phase", out_qual, 0);
    end
  endtask

  task automatic drain();
    while (pend.size() > 0 || hold.size() > 0 || vq.size() > 0 || bq.size() > 0) step();
    repeat (6) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 data", out_data, 0);
    chk("R11 qual", out_qual, 0);
    chk("R11 flag", out_vbi_flag, 0);
    chk("R11 vid_pop", vid_pop, 0);
    chk("R11 vbi_pop", vbi_pop, 0);
    rst = 1'b0;

    // byte mode, back-to-back video
    tag = "R1 byte data";
    for (int i = 0; i < 6; i++) vq.push_back({4'b0, 32'h1122_3344 + i * 32'h0107_0301});
    drain();

    // byte mode, isolated words with gaps
    for (int i = 0; i < 4; i++) begin
      vq.push_back({4'b0, 32'hA5C3_0F81 ^ (i * 32'h1111_0000)});
      repeat (i + 5) step();
    end
    drain();

    // word mode
    cfg_wide = 1'b1;
    tag = "R2 word lanes";
    for (int i = 0; i < 5; i++) vq.push_back({4'b0, 32'hC0DE_0000 + i * 32'h0003_1207});
    drain();
    cfg_wide = 1'b0;
    repeat (4) step();

    // VBI priority and unbroken line
    tag = "R6 vbi line";
    for (int i = 0; i < 3; i++) vq.push_back({4'b0, 32'h7000_0000 + i});
    for (int i = 0; i < 3; i++) bq.push_back({i == 2, 32'hB100_0000 + i * 32'h0101});
    drain();
    // partial line waits, then cuts in at a boundary
    bq.push_back({1'b0, 32'hD0D0_0001});
    bq.push_back({1'b0, 32'hD0D0_0002});
    for (int i = 0; i < 4; i++) vq.push_back({4'b0, 32'h5500_00AA + i * 32'h10});
    repeat (6) step();
    bq.push_back({1'b1, 32'hD0D0_0003});
    drain();
    // VBI in word mode
    cfg_wide = 1'b1;
    vq.push_back({4'b0, 32'h1234_5678});
    bq.push_back({1'b0, 32'hEE01_EE02});
    bq.push_back({1'b1, 32'hEE03_EE04});
    drain();
    cfg_wide = 1'b0;
    repeat (4) step();

    // embedded codes in byte mode, all F/V combinations
    cfg_embed_codes = 1'b1;
    tag = "R8 codes";
    vq.push_back({4'b1000, 32'h0A0B_0C0D});
    vq.push_back({4'b0000, 32'h1A1B_1C1D});
    vq.push_back({4'b0100, 32'h2A2B_2C2D});
    bq.push_back({1'b1, 32'hBEEF_0001});
    vq.push_back({4'b1111, 32'h3A3B_3C3D});
    vq.push_back({4'b1010, 32'h4A4B_4C4D});
    vq.push_back({4'b0110, 32'h5A5B_5C5D});
    vq.push_back({4'b1001, 32'h6A6B_6C6D});
    vq.push_back({4'b0101, 32'h7A7B_7C7D});
    drain();

    // code request ignored in word mode
    cfg_wide = 1'b1;
    tag = "R9 no codes in word mode";
    vq.push_back({4'b1000, 32'h8888_1111});
    vq.push_back({4'b0100, 32'h9999_2222});
    vq.push_back({4'b1111, 32'hAAAA_3333});
    drain();
    cfg_wide = 1'b0;
    cfg_embed_codes = 1'b0;
    repeat (4) step();

    // gated clock on the qualifier pin
    cfg_gate_clk = 1'b1;
    tag = "R1 byte data gated";
    for (int i = 0; i < 3; i++) vq.push_back({4'b0, 32'h0F1E_2D3C + i});
    repeat (6) step();
    vq.push_back({4'b0, 32'h4B5A_6978});
    repeat (9) step();
    bq.push_back({1'b1, 32'h8796_A5B4});
    drain();
    cfg_gate_clk = 1'b0;
    repeat (3) step();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule